// File: doc/BRIEF.md
# Banked Data Memory Controller

This block is the data-memory side of a small 8-bit controller core. Each cycle it takes one byte address, an operation code, a bit index and write data. It resolves the address to one of three places: the shared control-register window, one of several general-purpose RAM banks, or a display RAM bank. It returns the addressed byte combinationally and applies byte writes and single-bit set/clear at the next rising clock edge.

Two of the control-register slots are windows, not storage. A pointer register sits behind each window, and the bank register picks which bank the upper half of the address space reaches. The display bank can only be reached through the second pointer window. Any access that lands on nothing reads 00h, and a write to it is dropped.

Top module: `dmem_bank_ctrl`

## Requirements
- R1: Addresses 00h..3Fh form one control-register window that reads and writes the same storage for every bank-register value.
- R2: With parameters at default, bank-register values 00h, 02h, 03h and 04h each select their own 64-byte general RAM at addresses 40h..7Fh. Bytes written in one bank are not visible in another.
- R3: A bank-register value above 04h (other than 01h), or a general-RAM address above 7Fh, reads 00h, and writes to it change nothing.
- R4: Display RAM occupies 40h..5Fh with bank register 01h. It is reached only through window 02h. With bank 01h, a direct access or a window-00h access at 40h or above reads 00h and its writes are dropped.
- R5: With bank 01h, a window-02h access whose pointer is above 5Fh reads 00h, and writes to it are dropped. 5Fh itself is usable.
- R6: Address 00h accesses the location held in pointer register 01h. Address 02h accesses the location held in pointer register 03h. A pointer below 40h reaches the control-register window.
- R7: A window access whose pointer is 00h or 02h reads 00h, and its writes are dropped.
- R8: With parameters at default, control-register slots 15h..3Fh are unimplemented. They read 00h, and writes and bit operations to them are ignored.
- R9: The operation code is 00 for read only, 01 for byte write, 10 for bit set and 11 for bit clear. A bit operation changes only the bit selected by `bitSel`, and it applies to every writable location, windows included.
- R10: Writes take effect at the rising clock edge, and reads follow the address in the same cycle. A synchronous reset clears the bank register (04h), both pointers (01h, 03h) and the other control registers to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opKind | input | 2 | 00 read, 01 byte write, 10 bit set, 11 bit clear |
| addr | input | 8 | Direct byte address |
| bitSel | input | 3 | Bit index for set/clear |
| wrData | input | 8 | Byte write data |
| rdData | output | 8 | Byte at the resolved location, 00h if unmapped |

## Verification
The bench targets the places where a faulty decoder would still look plausible. If the bank gap were mishandled, data would alias into bank 0 or into the wrong bank. If the display were reachable directly or through window 00h, the display byte or the general RAM at the same offset would be corrupted. A pointer that aims at its own window would recurse or return stale data instead of 00h. Off-by-one limits at 5Fh, 7Fh and the last implemented control slot would either hide a usable byte or expose a phantom one. A bit operation that wrote the whole byte would disturb its neighbouring bits.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_SET   = 2'b10,
    OP_CLR   = 2'b11
  } op_t;

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_SFR  = 2'd1,
    RG_GP   = 2'd2,
    RG_DISP = 2'd3
  } region_t;

  localparam int BANK_SEL_W = 4;

  // strobes from decode to storage
  typedef struct packed {
    region_t               region;
    logic [BANK_SEL_W-1:0] gpBank;
    logic [7:0]            loc;     // SFR address or offset from 40h
    logic                  wrStb;
    logic                  setStb;
    logic                  clrStb;
  } strobe_t;
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
  import dmem_pkg::*;
#(
  parameter int NUM_GP_BANKS = 4,
  parameter int GP_LAST      = 8'h7F,
  parameter int DISP_LAST    = 8'h5F,
  parameter int SFR_LAST     = 8'h14
) (
  input  logic [1:0] opKind,
  input  logic [7:0] addr,
  input  logic [7:0] bankPtr,
  input  logic [7:0] ptr0,
  input  logic [7:0] ptr1,
  output strobe_t    stb
);
  localparam logic [7:0] GP_TOP   = 8'(GP_LAST);
  localparam logic [7:0] DISP_TOP = 8'(DISP_LAST);
  localparam logic [7:0] SFR_TOP  = 8'(SFR_LAST);
  localparam logic [7:0] BANK_TOP = 8'(NUM_GP_BANKS);
  localparam logic [7:0] RAM_BASE = 8'h40;

  logic       viaP0, viaP1, loopBack, anyHit;
  logic [7:0] effAddr;
  op_t        op;

  always_comb begin
    op       = op_t'(opKind);
    viaP0    = (addr == 8'h00);
    viaP1    = (addr == 8'h02);
    effAddr  = viaP0 ? ptr0 : (viaP1 ? ptr1 : addr);
    loopBack = (viaP0 || viaP1) && (effAddr == 8'h00 || effAddr == 8'h02);

    stb        = '0;
    stb.region = RG_NONE;
    if (loopBack) begin
      stb.region = RG_NONE;
    end else if (effAddr < RAM_BASE) begin
      if (effAddr <= SFR_TOP) begin
        stb.region = RG_SFR;
        stb.loc    = effAddr;
      end
    end else if (bankPtr == 8'h00) begin
      if (effAddr <= GP_TOP) begin
        stb.region = RG_GP;
        stb.gpBank = '0;
        stb.loc    = effAddr - RAM_BASE;
      end
    end else if (bankPtr == 8'h01) begin
      if (viaP1 && effAddr <= DISP_TOP) begin
        stb.region = RG_DISP;
        stb.loc    = effAddr - RAM_BASE;
      end
    end else if (bankPtr <= BANK_TOP) begin
      if (effAddr <= GP_TOP) begin
        stb.region = RG_GP;
        stb.gpBank = BANK_SEL_W'(bankPtr - 8'd1);
        stb.loc    = effAddr - RAM_BASE;
      end
    end

    anyHit     = (stb.region != RG_NONE);
    stb.wrStb  = anyHit && (op == OP_WRITE);
    stb.setStb = anyHit && (op == OP_SET);
    stb.clrStb = anyHit && (op == OP_CLR);
  end
endmodule

// File: rtl/dmem_store.sv
module dmem_store
  import dmem_pkg::*;
#(
  parameter int NUM_GP_BANKS = 4,
  parameter int GP_LAST      = 8'h7F,
  parameter int DISP_LAST    = 8'h5F,
  parameter int SFR_LAST     = 8'h14
) (
  input  logic       clk,
  input  logic       rst,
  input  strobe_t    stb,
  input  logic [2:0] bitSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic [7:0] bankPtr,
  output logic [7:0] ptr0,
  output logic [7:0] ptr1
);
  localparam int SFR_NUM    = SFR_LAST + 1;
  localparam int SFR_AW     = $clog2(SFR_NUM);
  localparam int GP_DEPTH   = GP_LAST - 8'h40 + 1;
  localparam int GP_AW      = $clog2(GP_DEPTH);
  localparam int DISP_DEPTH = DISP_LAST - 8'h40 + 1;
  localparam int DISP_AW    = $clog2(DISP_DEPTH);

  logic [7:0] sfrQ   [SFR_NUM];
  logic [7:0] gpRd   [NUM_GP_BANKS];
  logic [7:0] dispMem[DISP_DEPTH];
  logic [7:0] curRd, newVal, bitMask;
  logic       anyWe, sfrWe, gpWe, dispWe;

  assign anyWe  = stb.wrStb || stb.setStb || stb.clrStb;
  assign sfrWe  = anyWe && (stb.region == RG_SFR);
  assign gpWe   = anyWe && (stb.region == RG_GP);
  assign dispWe = anyWe && (stb.region == RG_DISP);

  // control registers; slots 00h and 02h are never addressed by decode
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SFR_NUM; i++) sfrQ[i] <= 8'h00;
    end else if (sfrWe) begin
      sfrQ[stb.loc[SFR_AW-1:0]] <= newVal;
    end
  end

  assign ptr0    = sfrQ[1];
  assign ptr1    = sfrQ[3];
  assign bankPtr = sfrQ[4];

  // one storage block per general-purpose bank
  for (genvar b = 0; b < NUM_GP_BANKS; b++) begin : g_bank
    logic [7:0] mem [GP_DEPTH];
    always_ff @(posedge clk) begin
      if (gpWe && stb.gpBank == BANK_SEL_W'(b))
        mem[stb.loc[GP_AW-1:0]] <= newVal;
    end
    assign gpRd[b] = mem[stb.loc[GP_AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (dispWe) dispMem[stb.loc[DISP_AW-1:0]] <= newVal;
  end

  always_comb begin
    case (stb.region)
      RG_SFR:  curRd = sfrQ[stb.loc[SFR_AW-1:0]];
      RG_GP:   curRd = gpRd[stb.gpBank];
      RG_DISP: curRd = dispMem[stb.loc[DISP_AW-1:0]];
      default: curRd = 8'h00;
    endcase
    bitMask = 8'h01 << bitSel;
    if (stb.setStb)      newVal = curRd | bitMask;
    else if (stb.clrStb) newVal = curRd & ~bitMask;
    else                 newVal = wrData;
  end

  assign rdData = curRd;
endmodule

// File: rtl/dmem_bank_ctrl.sv
module dmem_bank_ctrl
  import dmem_pkg::*;
#(
  parameter int NUM_GP_BANKS = 4,
  parameter int GP_LAST      = 8'h7F,
  parameter int DISP_LAST    = 8'h5F,
  parameter int SFR_LAST     = 8'h14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] opKind,
  input  logic [7:0] addr,
  input  logic [2:0] bitSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);
  strobe_t    stb;
  logic [7:0] bankPtr, ptr0, ptr1;

  dmem_decode #(
    .NUM_GP_BANKS(NUM_GP_BANKS), .GP_LAST(GP_LAST),
    .DISP_LAST(DISP_LAST), .SFR_LAST(SFR_LAST)
  ) decode_i (
    .opKind(opKind), .addr(addr), .bankPtr(bankPtr),
    .ptr0(ptr0), .ptr1(ptr1), .stb(stb)
  );

  dmem_store #(
    .NUM_GP_BANKS(NUM_GP_BANKS), .GP_LAST(GP_LAST),
    .DISP_LAST(DISP_LAST), .SFR_LAST(SFR_LAST)
  ) store_i (
    .clk(clk), .rst(rst), .stb(stb), .bitSel(bitSel), .wrData(wrData),
    .rdData(rdData), .bankPtr(bankPtr), .ptr0(ptr0), .ptr1(ptr1)
  );
endmodule

// File: rtl/dmem_bank_ctrl_chk.sv
module dmem_bank_ctrl_chk #(
  parameter int NUM_GP_BANKS = 4,
  parameter int GP_LAST      = 8'h7F,
  parameter int DISP_LAST    = 8'h5F,
  parameter int SFR_LAST     = 8'h14
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] opKind,
  input logic [7:0] addr,
  input logic [2:0] bitSel,
  input logic [7:0] rdData,
  input logic [7:0] bankPtr,
  input logic [7:0] ptr0,
  input logic [7:0] ptr1
);
  localparam logic [7:0] GP_TOP   = 8'(GP_LAST);
  localparam logic [7:0] DISP_TOP = 8'(DISP_LAST);
  localparam logic [7:0] SFR_TOP  = 8'(SFR_LAST);
  localparam logic [7:0] BANK_TOP = 8'(NUM_GP_BANKS);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (bankPtr == 8'h00 && ptr0 == 8'h00 && ptr1 == 8'h00));

  assert_bank_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (bankPtr > BANK_TOP && addr >= 8'h40) |-> rdData == 8'h00);

  assert_disp_direct_R4: assert property (@(posedge clk) disable iff (rst)
    (bankPtr == 8'h01 && addr >= 8'h40) |-> rdData == 8'h00);

  assert_disp_end_R5: assert property (@(posedge clk) disable iff (rst)
    (bankPtr == 8'h01 && addr == 8'h02 && ptr1 > DISP_TOP) |-> rdData == 8'h00);

  assert_ptr_loop_R7: assert property (@(posedge clk) disable iff (rst)
    ((addr == 8'h00 && (ptr0 == 8'h00 || ptr0 == 8'h02)) ||
     (addr == 8'h02 && (ptr1 == 8'h00 || ptr1 == 8'h02))) |-> rdData == 8'h00);

  assert_sfr_hole_R8: assert property (@(posedge clk) disable iff (rst)
    (addr > SFR_TOP && addr < 8'h40) |-> rdData == 8'h00);

  assert_bit_set_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(opKind == 2'b10 && bankPtr == 8'h00 && addr >= 8'h40 && addr <= GP_TOP && !rst)
     && $stable(addr) && $stable(bankPtr))
    |-> rdData == ($past(rdData) | (8'h01 << $past(bitSel))));

  assert_bit_clr_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(opKind == 2'b11 && bankPtr == 8'h00 && addr >= 8'h40 && addr <= GP_TOP && !rst)
     && $stable(addr) && $stable(bankPtr))
    |-> rdData == ($past(rdData) & ~(8'h01 << $past(bitSel))));
endmodule

bind dmem_bank_ctrl dmem_bank_ctrl_chk #(
  .NUM_GP_BANKS(NUM_GP_BANKS), .GP_LAST(GP_LAST),
  .DISP_LAST(DISP_LAST), .SFR_LAST(SFR_LAST)
) chk_i (
  .clk(clk), .rst(rst), .opKind(opKind), .addr(addr), .bitSel(bitSel),
  .rdData(rdData), .bankPtr(bankPtr), .ptr0(ptr0), .ptr1(ptr1)
);

// File: tb/dmem_bank_ctrl_tb_top.sv
module dmem_bank_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] opKind = 2'b00;
  logic [7:0] addr = 8'h00;
  logic [2:0] bitSel = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dmem_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .opKind(opKind), .addr(addr),
    .bitSel(bitSel), .wrData(wrData), .rdData(rdData)
  );

  task automatic doOp(input logic [1:0] k, input logic [7:0] a,
                      input logic [2:0] b, input logic [7:0] d);
    @(negedge clk);
    opKind = k; addr = a; bitSel = b; wrData = d;
    @(posedge clk);
    #1 opKind = 2'b00;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    doOp(2'b01, a, 3'd0, d);
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    opKind = 2'b00; addr = a;
    #2;
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s addr=%02h actual=%02h expected=%02h", req, a, rdData, exp);
    end
  endtask

  task automatic t_reset;
    rdChk(8'h04, 8'h00, "R10 bank reg");
    rdChk(8'h01, 8'h00, "R10 ptr0");
    rdChk(8'h03, 8'h00, "R10 ptr1");
  endtask

  task automatic t_gp_banks;
    wr(8'h40, 8'h11); wr(8'h7F, 8'h22);
    rdChk(8'h40, 8'h11, "R2 bank0 low");
    rdChk(8'h7F, 8'h22, "R2 bank0 top");
    wr(8'h04, 8'h02); wr(8'h40, 8'h33);
    wr(8'h04, 8'h04); wr(8'h40, 8'h44);
    wr(8'h04, 8'h00); rdChk(8'h40, 8'h11, "R2 bank0 isolated");
    wr(8'h04, 8'h02); rdChk(8'h40, 8'h33, "R2 bank2");
    wr(8'h04, 8'h04); rdChk(8'h40, 8'h44, "R2 bank4");
  endtask

  task automatic t_gap;
    wr(8'h04, 8'h05); wr(8'h40, 8'h55);
    rdChk(8'h40, 8'h00, "R3 bank5 absent");
    wr(8'h04, 8'h00);
    rdChk(8'h40, 8'h11, "R3 no alias into bank0");
    wr(8'h80, 8'h66);
    rdChk(8'h80, 8'h00, "R3 past 7Fh");
    rdChk(8'h40, 8'h11, "R3 80h no wrap");
  endtask

  task automatic t_sfr;
    wr(8'h04, 8'h00); wr(8'h05, 8'hA5);
    wr(8'h04, 8'h03); rdChk(8'h05, 8'hA5, "R1 shared bank3");
    wr(8'h04, 8'h01); rdChk(8'h05, 8'hA5, "R1 shared bank1");
    wr(8'h3F, 8'hFF); rdChk(8'h3F, 8'h00, "R8 slot 3Fh");
    wr(8'h15, 8'h5C); rdChk(8'h15, 8'h00, "R8 slot 15h");
    wr(8'h14, 8'h3C); rdChk(8'h14, 8'h3C, "R8 last slot 14h");
  endtask

  task automatic t_indirect;
    wr(8'h04, 8'h00);
    wr(8'h01, 8'h41); wr(8'h00, 8'h77);
    rdChk(8'h41, 8'h77, "R6 window0 write");
    wr(8'h06, 8'h5A); wr(8'h03, 8'h06);
    rdChk(8'h02, 8'h5A, "R6 window2 to SFR");
    wr(8'h02, 8'h6B);
    rdChk(8'h06, 8'h6B, "R6 window2 write SFR");
  endtask

  task automatic t_loop;
    wr(8'h01, 8'h02);
    rdChk(8'h00, 8'h00, "R7 ptr0=02h");
    wr(8'h00, 8'h99);
    rdChk(8'h03, 8'h06, "R7 ptr1 untouched");
    rdChk(8'h01, 8'h02, "R7 ptr0 untouched");
    wr(8'h03, 8'h00);
    rdChk(8'h02, 8'h00, "R7 ptr1=00h");
  endtask

  task automatic t_display;
    wr(8'h04, 8'h01); wr(8'h03, 8'h41); wr(8'h02, 8'hC3);
    rdChk(8'h02, 8'hC3, "R4 display via window2");
    rdChk(8'h41, 8'h00, "R4 direct read blocked");
    wr(8'h01, 8'h41);
    rdChk(8'h00, 8'h00, "R4 window0 read blocked");
    wr(8'h41, 8'h0F); wr(8'h00, 8'hF0);
    rdChk(8'h02, 8'hC3, "R4 blocked writes dropped");
    wr(8'h04, 8'h00);
    rdChk(8'h41, 8'h77, "R4 bank0 separate");
    wr(8'h04, 8'h01); wr(8'h03, 8'h5F); wr(8'h02, 8'hE1);
    rdChk(8'h02, 8'hE1, "R5 last display byte");
    wr(8'h03, 8'h60);
    rdChk(8'h02, 8'h00, "R5 past end");
    wr(8'h02, 8'h12);
    rdChk(8'h02, 8'h00, "R5 past end write");
    wr(8'h03, 8'h5F);
    rdChk(8'h02, 8'hE1, "R5 no wrap");
  endtask

  task automatic t_bits;
    wr(8'h04, 8'h00); wr(8'h50, 8'h00);
    doOp(2'b10, 8'h50, 3'd7, 8'hFF); rdChk(8'h50, 8'h80, "R9 set bit7");
    doOp(2'b10, 8'h50, 3'd0, 8'h00); rdChk(8'h50, 8'h81, "R9 set bit0");
    doOp(2'b11, 8'h50, 3'd7, 8'hFF); rdChk(8'h50, 8'h01, "R9 clear bit7");
    doOp(2'b11, 8'h06, 3'd3, 8'h00); rdChk(8'h06, 8'h63, "R9 clear SFR bit3");
    wr(8'h04, 8'h01); wr(8'h03, 8'h41);
    doOp(2'b10, 8'h02, 3'd2, 8'h00); rdChk(8'h02, 8'hC7, "R9 set display bit2");
    doOp(2'b10, 8'h3F, 3'd1, 8'h00); rdChk(8'h3F, 8'h00, "R8 bit set on hole");
  endtask

  task automatic t_reset_again;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rdChk(8'h04, 8'h00, "R10 bank reg after reset");
    rdChk(8'h03, 8'h00, "R10 ptr1 after reset");
    rdChk(8'h06, 8'h00, "R10 SFR after reset");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_gp_banks();
    t_gap();
    t_sfr();
    t_indirect();
    t_loop();
    t_display();
    t_bits();
    t_reset_again();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule